// File: doc/BRIEF.md
# Twin-Predicated Element Pair Sequencer

This block steps through a two-operand vector operation, such as a register-to-register move or an element-wise load or store, where the source and the destination each carry their own predicate mask. On a start pulse it captures the configuration of both operands. Each operand has a raw register number, an optional redirect entry, a vector/scalar flag and a mask. A vector length is captured with them. The block then produces a stream of (source register, destination register) pairs, at most one per cycle, under a valid/ready handshake. A one-cycle done pulse closes the sequence.

Each operand has its own element counter. Each counter jumps over the positions its own mask disables, so a dense run of enabled source elements can be spread over scattered destination slots, and the reverse. A scalar operand keeps its base register for every pair. A scalar source with a vector destination therefore broadcasts. A scalar destination ends the sequence after its first pair. The register file and the data path that performs the actual copy or conversion are outside this block.

Top module: `tpseq_top`

## Requirements
- R1: At start, each operand's base register is the redirect index when that operand's redirect enable is 1, and the raw register number otherwise.
- R2: With both operands vector, the k-th pair is (source base + position of the k-th set source mask bit, destination base + position of the k-th set destination mask bit), with the sums taken modulo the register count (32 by default). Mask bit n belongs to element n.
- R3: No pair uses an element position at or above the effective vector length. The effective vector length is the minimum of the captured length and MAX_VL (16). The sequence ends as soon as either operand runs out of enabled positions.
- R4: A scalar source with a vector destination issues the source base register unchanged in every pair, once per enabled destination position. The source mask has no effect.
- R5: A vector source with a scalar destination issues exactly one pair: the first enabled source element paired with the destination base. The destination mask has no effect.
- R6: While pairValid is high and pairReady is low, pairValid, pairSrc and pairDst hold their values. A pair is consumed only on a cycle where both are high. pairValid is never high while busy is low.
- R7: After reset, busy, pairValid and done are low. At the end of each sequence, done is high for exactly one cycle, and busy is low in the cycle after done.
- R8: A start pulse while busy is high is ignored. The running sequence keeps the configuration it captured.
- R9: A vector length of 0 produces no pair. done follows two cycles after the start edge.
- R10: With pairReady held high, a sequence with N pairs raises done N+2 cycles after the start edge, whatever the gaps in the masks. The exception is a scalar destination that issued its pair, which raises done after N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture configuration and begin; ignored while busy |
| srcReg | input | REG_W | Raw source register number |
| srcIsVec | input | 1 | Source is a vector operand |
| srcRedirEn | input | 1 | Source redirect entry active |
| srcRedirIdx | input | REG_W | Source redirect register index |
| srcMask | input | MAX_VL | Source predicate, bit n enables element n |
| dstReg | input | REG_W | Raw destination register number |
| dstIsVec | input | 1 | Destination is a vector operand |
| dstRedirEn | input | 1 | Destination redirect entry active |
| dstRedirIdx | input | REG_W | Destination redirect register index |
| dstMask | input | MAX_VL | Destination predicate, bit n enables element n |
| vl | input | IDX_W | Vector length |
| busy | output | 1 | Sequence in progress |
| pairValid | output | 1 | A pair is presented |
| pairReady | input | 1 | Consumer accepts the presented pair |
| pairSrc | output | REG_W | Source register of the pair |
| pairDst | output | REG_W | Destination register of the pair |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A start sampled at a clock edge makes the first pair visible in the very next cycle, because the element search is combinational from the captured state. Each accepted pair advances the counters at the following edge. done arrives one cycle after the cycle in which the sequence is seen to end, so with ready held high it lands N+2 cycles after the start edge (N+1 for a scalar destination). The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start edge and compares each accepted pair, the pair count and the done cycle against a model built from the requirements. Under random ready stalls it drops only the latency comparison.

// File: rtl/tpseq_pkg.sv
package tpseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // capture configuration, clear counters
    logic advance;  // current pair accepted
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic exhausted;  // an operand has no enabled position below VL
    logic dstScalar;  // destination captured as scalar
  } seqStatus_t;
endpackage

// File: rtl/tpseq_skip.sv
// Priority search: lowest enabled mask position at or above 'from'.
module tpseq_skip #(
  parameter int MAX_VL = 16,
  parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
  input  logic [MAX_VL-1:0] mask,
  input  logic [IDX_W-1:0]  from,
  input  logic              isVec,
  output logic [IDX_W-1:0]  pos
);
  always_comb begin
    pos = isVec ? IDX_W'(MAX_VL) : from;
    if (isVec) begin
      for (int k = MAX_VL - 1; k >= 0; k--) begin
        if (mask[k] && (IDX_W'(k) >= from)) pos = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/tpseq_lane.sv
// One operand: captured base, mode, mask and its own element counter.
module tpseq_lane
  import tpseq_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int MAX_VL = 16,
  parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [REG_W-1:0]  rawReg,
  input  logic              redirEn,
  input  logic [REG_W-1:0]  redirIdx,
  input  logic              isVec,
  input  logic [MAX_VL-1:0] mask,
  output logic [IDX_W-1:0]  pos,
  output logic [REG_W-1:0]  regOut,
  output logic              isVecQ
);
  localparam int SUM_W = REG_W + IDX_W;

  logic [REG_W-1:0]  baseQ;
  logic [MAX_VL-1:0] maskQ;
  logic [IDX_W-1:0]  cntQ;
  logic [SUM_W-1:0]  sum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      isVecQ <= 1'b0;
      maskQ  <= '0;
      cntQ   <= '0;
    end else if (strobe.load) begin
      baseQ  <= redirEn ? redirIdx : rawReg;
      isVecQ <= isVec;
      maskQ  <= mask;
      cntQ   <= '0;
    end else if (strobe.advance && isVecQ) begin
      cntQ <= pos + IDX_W'(1);
    end
  end

  tpseq_skip #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_skip (
    .mask(maskQ), .from(cntQ), .isVec(isVecQ), .pos(pos)
  );

  assign sum    = SUM_W'(baseQ) + SUM_W'(pos);
  assign regOut = isVecQ ? sum[REG_W-1:0] : baseQ;
endmodule

// File: rtl/tpseq_dp.sv
// Datapath: two operand lanes plus the captured vector length.
module tpseq_dp
  import tpseq_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int MAX_VL = 16,
  parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [REG_W-1:0]  srcReg,
  input  logic              srcIsVec,
  input  logic              srcRedirEn,
  input  logic [REG_W-1:0]  srcRedirIdx,
  input  logic [MAX_VL-1:0] srcMask,
  input  logic [REG_W-1:0]  dstReg,
  input  logic              dstIsVec,
  input  logic              dstRedirEn,
  input  logic [REG_W-1:0]  dstRedirIdx,
  input  logic [MAX_VL-1:0] dstMask,
  input  logic [IDX_W-1:0]  vl,
  output seqStatus_t        status,
  output logic [REG_W-1:0]  pairSrc,
  output logic [REG_W-1:0]  pairDst
);
  localparam int NLANE = 2;  // lane 0 = source, lane 1 = destination

  logic [NLANE-1:0][REG_W-1:0]  rawReg, redirIdx, regOut;
  logic [NLANE-1:0][MAX_VL-1:0] mask;
  logic [NLANE-1:0][IDX_W-1:0]  pos;
  logic [NLANE-1:0]             redirEn, isVec, isVecQ, laneOut;
  logic [IDX_W-1:0]             vlQ;

  assign rawReg   = {dstReg, srcReg};
  assign redirIdx = {dstRedirIdx, srcRedirIdx};
  assign mask     = {dstMask, srcMask};
  assign redirEn  = {dstRedirEn, srcRedirEn};
  assign isVec    = {dstIsVec, srcIsVec};

  always_ff @(posedge clk) begin
    if (!rstN)            vlQ <= '0;
    else if (strobe.load) vlQ <= (vl > IDX_W'(MAX_VL)) ? IDX_W'(MAX_VL) : vl;
  end

  for (genvar g = 0; g < NLANE; g++) begin : gLane
    tpseq_lane #(.REG_W(REG_W), .MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_lane (
      .clk(clk), .rstN(rstN), .strobe(strobe),
      .rawReg(rawReg[g]), .redirEn(redirEn[g]), .redirIdx(redirIdx[g]),
      .isVec(isVec[g]), .mask(mask[g]),
      .pos(pos[g]), .regOut(regOut[g]), .isVecQ(isVecQ[g])
    );
    assign laneOut[g] = (pos[g] >= vlQ);
  end

  assign status.exhausted = |laneOut;
  assign status.dstScalar = !isVecQ[1];
  assign pairSrc = regOut[0];
  assign pairDst = regOut[1];
endmodule

// File: rtl/tpseq_ctrl.sv
// Control FSM: idle -> run -> finish (done) -> idle.
module tpseq_ctrl
  import tpseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       pairReady,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       pairValid,
  output logic       busy,
  output logic       done
);
  seqState_t stateQ, stateD;

  always_comb begin
    pairValid      = (stateQ == ST_RUN) && !status.exhausted;
    strobe.load    = (stateQ == ST_IDLE) && start;
    strobe.advance = pairValid && pairReady;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (start) stateD = ST_RUN;
      ST_RUN: begin
        if (status.exhausted) stateD = ST_FIN;
        else if (strobe.advance && status.dstScalar) stateD = ST_FIN;
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = (stateQ == ST_FIN);
endmodule

// File: rtl/tpseq_top.sv
module tpseq_top
  import tpseq_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int MAX_VL = 16,
  parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [REG_W-1:0]  srcReg,
  input  logic              srcIsVec,
  input  logic              srcRedirEn,
  input  logic [REG_W-1:0]  srcRedirIdx,
  input  logic [MAX_VL-1:0] srcMask,
  input  logic [REG_W-1:0]  dstReg,
  input  logic              dstIsVec,
  input  logic              dstRedirEn,
  input  logic [REG_W-1:0]  dstRedirIdx,
  input  logic [MAX_VL-1:0] dstMask,
  input  logic [IDX_W-1:0]  vl,
  output logic              busy,
  output logic              pairValid,
  input  logic              pairReady,
  output logic [REG_W-1:0]  pairSrc,
  output logic [REG_W-1:0]  pairDst,
  output logic              done
);
  seqStrobe_t strobe;
  seqStatus_t status;

  tpseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .pairReady(pairReady),
    .status(status), .strobe(strobe), .pairValid(pairValid),
    .busy(busy), .done(done)
  );

  tpseq_dp #(.REG_W(REG_W), .MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcReg(srcReg), .srcIsVec(srcIsVec), .srcRedirEn(srcRedirEn),
    .srcRedirIdx(srcRedirIdx), .srcMask(srcMask),
    .dstReg(dstReg), .dstIsVec(dstIsVec), .dstRedirEn(dstRedirEn),
    .dstRedirIdx(dstRedirIdx), .dstMask(dstMask),
    .vl(vl), .status(status), .pairSrc(pairSrc), .pairDst(pairDst)
  );
endmodule

// File: rtl/tpseq_chk.sv
module tpseq_chk #(
  parameter int REG_W  = 5,
  parameter int MAX_VL = 16,
  parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             pairValid,
  input logic             pairReady,
  input logic [REG_W-1:0] pairSrc,
  input logic [REG_W-1:0] pairDst,
  input logic             done,
  input logic [IDX_W-1:0] vl
);
  logic [IDX_W:0] issued;

  always_ff @(posedge clk) begin
    if (!rstN)                  issued <= '0;
    else if (start && !busy)    issued <= '0;
    else if (pairValid && pairReady) issued <= issued + 1'b1;
  end

  // R3: never more pairs than the longest possible vector
  always_comb begin
    if (rstN) a_r3_count_bound: assert (issued <= (IDX_W+1)'(MAX_VL));
  end

  // R6: presented pair held while stalled
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    pairValid && !pairReady |=> pairValid && $stable(pairSrc) && $stable(pairDst));

  // R6: no pair outside a sequence
  a_r6_valid_busy: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> busy);

  // R7: done is a single cycle and the block is then idle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  // R7: done never coincides with a pair
  a_r7_done_no_pair: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !pairValid);

  // R9: zero length gives no pair, then done
  a_r9_vl_zero: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && (vl == '0) |=> !pairValid ##1 done);
endmodule

bind tpseq_top tpseq_chk #(.REG_W(REG_W), .MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .pairValid(pairValid),
  .pairReady(pairReady), .pairSrc(pairSrc), .pairDst(pairDst), .done(done),
  .vl(vl)
);

// File: tb/sim_tpseq_top.sv
`timescale 1ns/1ps
module sim_tpseq_top;
  localparam int REG_W  = 5;
  localparam int MAX_VL = 16;
  localparam int IDX_W  = $clog2(MAX_VL + 1);
  localparam int NREG   = 1 << REG_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [REG_W-1:0] srcReg = '0, srcRedirIdx = '0, dstReg = '0, dstRedirIdx = '0;
  logic srcIsVec = 1'b0, srcRedirEn = 1'b0, dstIsVec = 1'b0, dstRedirEn = 1'b0;
  logic [MAX_VL-1:0] srcMask = '0, dstMask = '0;
  logic [IDX_W-1:0] vl = '0;
  logic pairReady = 1'b0;
  logic busy, pairValid, done;
  logic [REG_W-1:0] pairSrc, pairDst;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  int expSrc [0:MAX_VL];
  int expDst [0:MAX_VL];
  int expN;

  always #10 clk = ~clk;  // 50 MHz

  tpseq_top #(.REG_W(REG_W), .MAX_VL(MAX_VL)) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .srcReg(srcReg), .srcIsVec(srcIsVec), .srcRedirEn(srcRedirEn),
    .srcRedirIdx(srcRedirIdx), .srcMask(srcMask),
    .dstReg(dstReg), .dstIsVec(dstIsVec), .dstRedirEn(dstRedirEn),
    .dstRedirIdx(dstRedirIdx), .dstMask(dstMask), .vl(vl),
    .busy(busy), .pairValid(pairValid), .pairReady(pairReady),
    .pairSrc(pairSrc), .pairDst(pairDst), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL R6 watchdog: actual=%0d cycles expected below 150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // expected pair list from the requirements
  task automatic buildExp(input int sReg, input bit sVec, input bit sRe, input int sRi,
                          input logic [MAX_VL-1:0] sM,
                          input int dReg, input bit dVec, input bit dRe, input int dRi,
                          input logic [MAX_VL-1:0] dM, input int len);
    int sb = sRe ? sRi : sReg;
    int db = dRe ? dRi : dReg;
    int ev = (len > MAX_VL) ? MAX_VL : len;
    int i = 0;
    int j = 0;
    expN = 0;
    while (1) begin
      if (sVec) while (i < ev && !sM[i]) i++;
      if (dVec) while (j < ev && !dM[j]) j++;
      if (i >= ev || j >= ev) break;
      expSrc[expN] = sVec ? (sb + i) % NREG : sb;
      expDst[expN] = dVec ? (db + j) % NREG : db;
      expN++;
      if (sVec) i++;
      if (dVec) j++;
      else break;
    end
  endtask

  task automatic runSeq(input string tag,
                        input int sReg, input bit sVec, input bit sRe, input int sRi,
                        input logic [MAX_VL-1:0] sM,
                        input int dReg, input bit dVec, input bit dRe, input int dRi,
                        input logic [MAX_VL-1:0] dM, input int len,
                        input bit stall, input bit midStart);
    int k = 0;
    int doneCyc = -1;
    int latency;
    buildExp(sReg, sVec, sRe, sRi, sM, dReg, dVec, dRe, dRi, dM, len);
    latency = expN + ((dVec || expN == 0) ? 2 : 1);
    @(negedge clk);
    srcReg = REG_W'(sReg); srcIsVec = sVec; srcRedirEn = sRe; srcRedirIdx = REG_W'(sRi);
    srcMask = sM;
    dstReg = REG_W'(dReg); dstIsVec = dVec; dstRedirEn = dRe; dstRedirIdx = REG_W'(dRi);
    dstMask = dM; vl = IDX_W'(len);
    start = 1'b1;
    pairReady = 1'b0;
    @(negedge clk);
    for (int cyc = 1; cyc < 400; cyc++) begin
      pairReady = stall ? (($urandom % 3) != 0) : 1'b1;
      if (midStart && cyc == 2) begin
        // R8: new start with different settings while busy
        start = 1'b1;
        srcReg = ~srcReg; srcMask = ~srcMask; dstMask = ~dstMask;
        srcIsVec = ~srcIsVec; dstIsVec = 1'b1; vl = IDX_W'(MAX_VL);
      end else begin
        start = 1'b0;
      end
      if (pairValid && pairReady) begin
        if (k < expN) begin
          check(pairSrc == REG_W'(expSrc[k]), tag, "pair source", pairSrc, expSrc[k]);
          check(pairDst == REG_W'(expDst[k]), tag, "pair destination", pairDst, expDst[k]);
        end
        k++;
      end
      if (done) begin
        doneCyc = cyc;
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    pairReady = 1'b0;
    check(k == expN, tag, "pair count", k, expN);
    check(doneCyc > 0, "R7", "done seen", doneCyc, latency);
    if (!stall) check(doneCyc == latency, "R10", "done cycle", doneCyc, latency);
    @(negedge clk);
    check(!done && !busy, "R7", "idle after done", {done, busy}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!busy && !pairValid && !done, "R7", "reset outputs",
          {busy, pairValid, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !pairValid && !done, "R7", "idle after reset",
          {busy, pairValid, done}, 0);

    // R1 redirect on both operands
    runSeq("R1", 3, 1, 1, 20, 16'hFFFF, 7, 1, 1, 9, 16'hFFFF, 4, 0, 0);
    // R2 interleaved masks with wrap of register numbers
    runSeq("R2", 30, 1, 0, 0, 16'b0000_0000_1010_0101, 4, 1, 0, 0,
           16'b0000_1100_0011_0000, 16, 0, 0);
    // R3 length above MAX_VL clamps
    runSeq("R3", 0, 1, 0, 0, 16'hFFFF, 8, 1, 0, 0, 16'hFFFF, 31, 0, 0);
    // R3 masks beyond length ignored, source runs out first
    runSeq("R3", 1, 1, 0, 0, 16'hFF03, 2, 1, 0, 0, 16'hFFFF, 6, 0, 0);
    // R4 broadcast, source mask empty
    runSeq("R4", 11, 0, 0, 0, 16'h0000, 0, 1, 0, 0, 16'h8421, 16, 0, 0);
    // R5 single pair, destination mask empty
    runSeq("R5", 5, 1, 0, 0, 16'h0040, 17, 0, 0, 0, 16'h0000, 16, 0, 0);
    // R5 with no enabled source element
    runSeq("R5", 5, 1, 0, 0, 16'h0000, 17, 0, 0, 0, 16'hFFFF, 16, 0, 0);
    // R6 random stalls
    runSeq("R6", 2, 1, 0, 0, 16'h5A5A, 6, 1, 0, 0, 16'hC3C3, 16, 1, 0);
    // R8 start while busy
    runSeq("R8", 9, 1, 0, 0, 16'h00FF, 12, 1, 0, 0, 16'h0F0F, 16, 0, 1);
    // R9 zero length
    runSeq("R9", 1, 1, 0, 0, 16'hFFFF, 2, 1, 0, 0, 16'hFFFF, 0, 0, 0);
    // R10 sparse masks, ready held high
    runSeq("R10", 0, 1, 0, 0, 16'h8001, 0, 1, 0, 0, 16'h4002, 16, 0, 0);

    // R2 random mix of modes, lengths and stalls
    for (int n = 0; n < 250; n++) begin
      runSeq("R2", int'($urandom % NREG), bit'($urandom % 4 != 0), bit'($urandom % 2),
             int'($urandom % NREG), MAX_VL'($urandom),
             int'($urandom % NREG), bit'($urandom % 4 != 0), bit'($urandom % 2),
             int'($urandom % NREG), MAX_VL'($urandom),
             int'($urandom % (MAX_VL + 4)), bit'($urandom % 2), bit'($urandom % 8 == 0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule